// File: doc/BRIEF.md
# Double Bus Fault Detector

This block follows the processor through its exception-processing phases. It escalates a second bus error or address error to a permanent halt when that error lands while an earlier bus error, address error or reset is still being handled. An error that arrives in the idle phase is an ordinary error. The block records its cause and raises a one-clock request for the error exception to the sequencer. An exception-complete marker returns the block to idle. After that, further errors are ordinary again. Bus cycles that end in a retry never count as errors.

A single status line serves two purposes. While the block is halted, the line is held high without a break until reset. Otherwise, the sequencer can ask for short status indications of one, two or three clocks through a length input. Bus arbitration is passed through in every state, including the halt, so an external master can still take the bus while the block is locked up. Only reset releases the halt, and reset itself counts as an exception in progress.

Top module: `dbf_fault_guard`

## Requirements
- R1: While an exception is in progress (not halted, recorded cause not 0), a bus or address error without retry sets `halted_o` from the next clock on, and `status_o` goes high with it.
- R2: While idle (not halted, cause 0), a bus or address error without retry makes `exc_req_o` high for exactly the next clock and records the cause: 1 for a bus error, 2 for an address error. A bus error wins when both are present.
- R3: An error presented together with `retry_i` has no effect, whether the block is idle or in an exception: no request, no cause change and no halt.
- R4: Once halted, the block stays halted whatever arrives on the error, retry, completion and pulse inputs, until a clock edge with `rst_n` low.
- R5: While `halted_o` is high, `status_o` is high on every clock.
- R6: When not halted and no indication is running, a nonzero `pulse_len_i` of N (1 to 3) drives `status_o` high for exactly N clocks, starting with the clock after the request. Requests that arrive while an indication is running are ignored.
- R7: `arb_grant_o` equals `arb_req_i` delayed by one clock in every state, the halt included.
- R8: A clock edge with `rst_n` low leaves cause 3 (reset exception in progress), with `halted_o`, `status_o`, `exc_req_o` and `arb_grant_o` all low.
- R9: `exc_done_i` during an exception (and with no valid error) returns the block to idle with cause 0 on the next clock. If a valid error arrives in the same clock, the halt takes priority.
- R10: An error that arrives after completion has returned the block to idle is handled as an ordinary error (R2) and does not halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| berr_i | input | 1 | Bus error on the current cycle |
| aerr_i | input | 1 | Address error on the current cycle |
| retry_i | input | 1 | Current cycle ends in a retry; its error flags are void |
| exc_done_i | input | 1 | Exception sequence has completed |
| pulse_len_i | input | PULSE_W | Status indication length request, 0 means none |
| arb_req_i | input | 1 | External bus request |
| arb_grant_o | output | 1 | Bus grant, one clock after the request |
| exc_req_o | output | 1 | One-clock request to start error exception processing |
| cause_o | output | 2 | Recorded cause: 0 none, 1 bus, 2 address, 3 reset |
| halted_o | output | 1 | Double fault halt |
| status_o | output | 1 | Status line |

## Verification
Every output comes from a register. The halt, the cause, the exception request and the grant therefore change one clock after the edge that samples the stimulus. A status indication of length N is high during the N clocks that follow the request edge. The bench drives inputs on the falling edge and checks each directed result at the next falling edge, or at each of the N following falling edges for an indication. In addition, a reference model updated on each rising edge is compared against every output at every falling edge, so no result is sampled while registers are updating.

// File: rtl/dbf_pkg.sv
// Shared types for the double bus fault detector.
// Assumes two-bit encodings are sufficient for phase and cause.
package dbf_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_EXC  = 2'd1,
        PH_HALT = 2'd2
    } dbf_phase_e;

    typedef enum logic [1:0] {
        CZ_NONE  = 2'd0,
        CZ_BUS   = 2'd1,
        CZ_ADDR  = 2'd2,
        CZ_RESET = 2'd3
    } dbf_cause_e;
endpackage

// File: rtl/dbf_err_qual.sv
// Qualifies raw error flags from the bus cycle logic.
// Removes errors on retried cycles and picks the cause, with bus error first.
// Assumes the flags are valid in the clock in which the cycle terminates.
module dbf_err_qual
    import dbf_pkg::*;
(
    input  logic       berr_i,
    input  logic       aerr_i,
    input  logic       retry_i,
    output logic       err_valid_o,
    output dbf_cause_e err_cause_o
);
    // Combine the flags into one qualified event and its cause.
    always_comb begin
        err_valid_o = (berr_i | aerr_i) & ~retry_i;
        err_cause_o = berr_i ? CZ_BUS : CZ_ADDR;
    end
endmodule

// File: rtl/dbf_phase_fsm.sv
// Exception phase tracker: idle, exception in progress, halted.
// Reset enters the exception phase with cause reset. A qualified error during
// the exception phase halts; only reset leaves the halt.
// Assumes err_valid_i is already clear on retried cycles.
module dbf_phase_fsm
    import dbf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       err_valid_i,
    input  dbf_cause_e err_cause_i,
    input  logic       done_i,
    output dbf_phase_e phase_o,
    output dbf_cause_e cause_o,
    output logic       exc_req_o
);
    dbf_phase_e phase_q;
    dbf_cause_e cause_q;
    logic       req_q;

    // Phase, cause and the one-clock exception request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_EXC;
            cause_q <= CZ_RESET;
            req_q   <= 1'b0;
        end else begin
            req_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (err_valid_i) begin
                        phase_q <= PH_EXC;
                        cause_q <= err_cause_i;
                        req_q   <= 1'b1;
                    end
                end
                PH_EXC: begin
                    if (err_valid_i) begin
                        phase_q <= PH_HALT;
                    end else if (done_i) begin
                        phase_q <= PH_IDLE;
                        cause_q <= CZ_NONE;
                    end
                end
                PH_HALT: begin
                    phase_q <= PH_HALT;
                end
                default: begin
                    phase_q <= PH_HALT;
                end
            endcase
        end
    end

    assign phase_o   = phase_q;
    assign cause_o   = cause_q;
    assign exc_req_o = req_q;
endmodule

// File: rtl/dbf_pulse_timer.sv
// Down-counter for short status indications.
// Loads the requested length when idle and not frozen, then counts to zero.
// Assumes freeze_i is high for the whole halt; the count is cleared then.
module dbf_pulse_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             active_o
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Load, count down, or clear the indication counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else if (freeze_i) begin
            cnt_q <= ZERO;
        end else if (cnt_q != ZERO) begin
            cnt_q <= cnt_q - ONE;
        end else if (len_i != ZERO) begin
            cnt_q <= len_i;
        end
    end

    assign active_o = (cnt_q != ZERO);
endmodule

// File: rtl/dbf_arb_pass.sv
// Registers bus requests into grants, independent of the halt.
// Assumes a single external requester.
module dbf_arb_pass (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic grant_o
);
    logic grant_q;

    // Grant follows request one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) grant_q <= 1'b0;
        else        grant_q <= req_i;
    end

    assign grant_o = grant_q;
endmodule

// File: rtl/dbf_fault_guard.sv
// Top of the double bus fault detector.
// Connects the error qualifier, phase tracker, status timer and arbitration
// pass. Status is high for the whole halt, or for a requested short length.
// Assumes synchronous active-low reset and registered outputs throughout.
module dbf_fault_guard
    import dbf_pkg::*;
#(
    parameter int PULSE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               berr_i,
    input  logic               aerr_i,
    input  logic               retry_i,
    input  logic               exc_done_i,
    input  logic [PULSE_W-1:0] pulse_len_i,
    input  logic               arb_req_i,
    output logic               arb_grant_o,
    output logic               exc_req_o,
    output logic [1:0]         cause_o,
    output logic               halted_o,
    output logic               status_o
);
    logic       err_valid;
    dbf_cause_e err_cause;
    dbf_phase_e phase;
    dbf_cause_e cause;
    logic       pulse_on;
    logic       in_halt;

    dbf_err_qual u_qual (
        .berr_i      (berr_i),
        .aerr_i      (aerr_i),
        .retry_i     (retry_i),
        .err_valid_o (err_valid),
        .err_cause_o (err_cause)
    );

    dbf_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_valid_i (err_valid),
        .err_cause_i (err_cause),
        .done_i      (exc_done_i),
        .phase_o     (phase),
        .cause_o     (cause),
        .exc_req_o   (exc_req_o)
    );

    assign in_halt = (phase == PH_HALT);

    dbf_pulse_timer #(.CNT_W(PULSE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze_i (in_halt),
        .len_i    (pulse_len_i),
        .active_o (pulse_on)
    );

    dbf_arb_pass u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (arb_req_i),
        .grant_o (arb_grant_o)
    );

    // Drive the outputs from the phase and the timer.
    always_comb begin
        halted_o = in_halt;
        cause_o  = cause;
        status_o = in_halt | pulse_on;
    end
endmodule

// File: rtl/dbf_checks.sv
// Port-level properties of the double bus fault detector, bound to the top.
// Assumes cause 0 with no halt means idle; a nonzero cause means an exception.
module dbf_checks #(
    parameter int PULSE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               berr_i,
    input logic               aerr_i,
    input logic               retry_i,
    input logic               exc_done_i,
    input logic [PULSE_W-1:0] pulse_len_i,
    input logic               arb_req_i,
    input logic               arb_grant_o,
    input logic               exc_req_o,
    input logic [1:0]         cause_o,
    input logic               halted_o,
    input logic               status_o
);
    logic err_ok, is_idle, is_exc;
    assign err_ok  = (berr_i | aerr_i) & ~retry_i;
    assign is_idle = ~halted_o & (cause_o == 2'd0);
    assign is_exc  = ~halted_o & (cause_o != 2'd0);

    AST_DOUBLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        is_exc && err_ok |=> halted_o); // R1
    AST_FIRST_ERR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle && err_ok |=> exc_req_o && !halted_o); // R2
    AST_REQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |=> !exc_req_o); // R2
    AST_RETRY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle && retry_i |=> !exc_req_o && cause_o == 2'd0); // R3
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> halted_o); // R4
    AST_HALT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> status_o); // R5
    AST_GRANT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> arb_grant_o == $past(arb_req_i)); // R7
    AST_DONE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        is_exc && !err_ok && exc_done_i |=> cause_o == 2'd0 && !halted_o); // R9
endmodule

bind dbf_fault_guard dbf_checks #(.PULSE_W(PULSE_W)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .berr_i      (berr_i),
    .aerr_i      (aerr_i),
    .retry_i     (retry_i),
    .exc_done_i  (exc_done_i),
    .pulse_len_i (pulse_len_i),
    .arb_req_i   (arb_req_i),
    .arb_grant_o (arb_grant_o),
    .exc_req_o   (exc_req_o),
    .cause_o     (cause_o),
    .halted_o    (halted_o),
    .status_o    (status_o)
);

// File: tb/tb_dbf_fault_guard.sv
`timescale 1ns/1ps
module tb_dbf_fault_guard;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          berr_i = 1'b0, aerr_i = 1'b0, retry_i = 1'b0, exc_done_i = 1'b0;
    logic [PW-1:0] pulse_len_i = '0;
    logic          arb_req_i = 1'b0;
    logic          arb_grant_o, exc_req_o, halted_o, status_o;
    logic [1:0]    cause_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit started = 0;
    bit done_run = 0;

    always #2.5 clk = ~clk;

    dbf_fault_guard #(.PULSE_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .berr_i(berr_i), .aerr_i(aerr_i),
        .retry_i(retry_i), .exc_done_i(exc_done_i), .pulse_len_i(pulse_len_i),
        .arb_req_i(arb_req_i), .arb_grant_o(arb_grant_o), .exc_req_o(exc_req_o),
        .cause_o(cause_o), .halted_o(halted_o), .status_o(status_o)
    );

    // Reference model: 0 idle, 1 in exception, 2 halted.
    int m_ph = 1, m_cause = 3, m_cnt = 0, m_req = 0, m_gnt = 0;

    always @(posedge clk) begin
        int err, old_ph;
        started <= 1;
        cycles  <= cycles + 1;
        err    = ((berr_i | aerr_i) & ~retry_i) ? 1 : 0;
        old_ph = m_ph;
        if (!rst_n) begin
            m_ph = 1; m_cause = 3; m_cnt = 0; m_req = 0; m_gnt = 0;
        end else begin
            m_req = 0;
            if (old_ph == 0 && err == 1) begin
                m_ph = 1; m_cause = berr_i ? 1 : 2; m_req = 1;
            end else if (old_ph == 1 && err == 1) begin
                m_ph = 2;
            end else if (old_ph == 1 && exc_done_i) begin
                m_ph = 0; m_cause = 0;
            end
            if (old_ph == 2)         m_cnt = 0;
            else if (m_cnt > 0)      m_cnt = m_cnt - 1;
            else if (pulse_len_i != 0) m_cnt = int'(pulse_len_i);
            m_gnt = arb_req_i;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (started && !done_run) begin
            chk("R1", "halted_o", int'(halted_o), (m_ph == 2) ? 1 : 0);
            chk("R2", "exc_req_o", int'(exc_req_o), m_req);
            chk("R9", "cause_o", int'(cause_o), m_cause);
            chk("R5", "status_o", int'(status_o), (m_ph == 2 || m_cnt != 0) ? 1 : 0);
            chk("R7", "arb_grant_o", int'(arb_grant_o), m_gnt);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_in();
        berr_i = 0; aerr_i = 0; retry_i = 0; exc_done_i = 0; pulse_len_i = '0;
    endtask

    task automatic do_reset();
        rst_n = 0; clear_in(); tick(2); rst_n = 1;
    endtask

    task automatic pulse_test(input int n);
        pulse_len_i = PW'(n); tick(1); pulse_len_i = '0;
        for (int i = 0; i < n; i++) begin
            chk("R6", "status during indication", int'(status_o), 1);
            tick(1);
        end
        chk("R6", "status after indication", int'(status_o), 0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        chk("R8", "cause after reset", int'(cause_o), 3);
        chk("R8", "halted after reset", int'(halted_o), 0);
        chk("R8", "status after reset", int'(status_o), 0);
        chk("R8", "req after reset", int'(exc_req_o), 0);
        chk("R8", "grant after reset", int'(arb_grant_o), 0);

        exc_done_i = 1; tick(1); exc_done_i = 0;
        chk("R9", "idle after done", int'(cause_o), 0);

        pulse_test(1); pulse_test(2); pulse_test(3);
        // Request while busy is ignored.
        pulse_len_i = 2'd2; tick(1); pulse_len_i = 2'd3; tick(1); pulse_len_i = '0;
        chk("R6", "second clock of length 2", int'(status_o), 1);
        tick(1);
        chk("R6", "busy request ignored", int'(status_o), 0);

        // Retried errors in idle.
        berr_i = 1; aerr_i = 1; retry_i = 1; tick(1); clear_in();
        chk("R3", "retry in idle: req", int'(exc_req_o), 0);
        chk("R3", "retry in idle: cause", int'(cause_o), 0);

        // Ordinary address error.
        aerr_i = 1; tick(1); clear_in();
        chk("R2", "request on first error", int'(exc_req_o), 1);
        chk("R2", "address cause", int'(cause_o), 2);
        tick(1);
        chk("R2", "request lasts one clock", int'(exc_req_o), 0);

        // Complete, then a later error is ordinary.
        exc_done_i = 1; tick(1); clear_in();
        berr_i = 1; tick(1); clear_in();
        chk("R10", "late error not halted", int'(halted_o), 0);
        chk("R10", "late error bus cause", int'(cause_o), 1);

        // Retried error inside exception, then a real one.
        aerr_i = 1; retry_i = 1; tick(1); clear_in();
        chk("R3", "retry in exception: no halt", int'(halted_o), 0);
        berr_i = 1; tick(1); clear_in();
        chk("R1", "double fault halts", int'(halted_o), 1);
        chk("R1", "status with halt", int'(status_o), 1);

        // Nothing but reset releases the halt; arbitration still works.
        exc_done_i = 1; pulse_len_i = 2'd1; arb_req_i = 1; tick(1);
        chk("R7", "grant while halted", int'(arb_grant_o), 1);
        berr_i = 1; arb_req_i = 0; tick(1); clear_in();
        chk("R7", "grant drops while halted", int'(arb_grant_o), 0);
        for (int i = 0; i < 5; i++) begin
            chk("R4", "halt held", int'(halted_o), 1);
            chk("R5", "status held", int'(status_o), 1);
            exc_done_i = (i % 2 == 0); tick(1);
        end
        clear_in();

        // Reset exception: error with done in the same clock halts.
        do_reset();
        chk("R8", "reset releases halt", int'(halted_o), 0);
        berr_i = 1; exc_done_i = 1; tick(1); clear_in();
        chk("R9", "error beats done", int'(halted_o), 1);

        // Both errors in idle: bus wins.
        do_reset();
        exc_done_i = 1; tick(1); clear_in();
        berr_i = 1; aerr_i = 1; tick(1); clear_in();
        chk("R2", "bus error priority", int'(cause_o), 1);
        tick(2);

        done_run = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #(5ns * 5000);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        done_run = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule